// File: doc/BRIEF.md
# Crash Dump Capture with Indexed Readout

This block keeps a copy of crash information that would otherwise be lost when the chip goes through a system reset. A wide crash-info vector, made of a parameterised number of 32-bit words (at most 16), is presented at its input all the time. When a system-reset event arrives while capture is armed, the whole vector is latched into a snapshot. The arming bit then clears itself, so the snapshot survives all later resets until software arms capture again.

Software reads the snapshot one word at a time. It writes a word index into the control register and reads the selected word on a 32-bit read port. A constant attribute output reports how many words the dump holds. A lock register that software can only clear freezes the control register, so that a later fault cannot change the arming or the index.

The block's own reset (`rst_ni`) is separate from the system-reset event (`sys_reset_i`). A system reset clears only the arming bit. It does not clear the snapshot, the index or the lock.

Top module: `crash_dump_capture`

## Requirements
- R1: After block reset (synchronous, active low) the control register reads 0 (capture disarmed, index 0), the lock reads 1 and the read value is 0.
- R2: A control write while the lock is 1 takes effect on the next cycle. Write-data bit 0 is the capture enable and bits 7:4 are the word index. The `ctrl_o` readback has the same layout, and its bits 3:1 always read 0.
- R3: A lock write of 0 clears the lock. A lock write of 1 has no effect. Once the lock is 0 it stays 0 until block reset.
- R4: While the lock is 0, control writes are ignored. When a lock clear and a control write arrive in the same cycle, the control write still takes effect.
- R5: A system-reset event clears the capture enable on the next cycle, without a block reset. A control write in the same cycle is dropped. The index and the lock are unchanged.
- R6: A system-reset event with the capture enable set latches every word of the crash-info vector. A system-reset event with the enable clear leaves the snapshot unchanged.
- R7: The read value is snapshot word k when the index is k. Word k is `info_i[32k+31:32k]`. The read value follows a change of index or snapshot in the cycle after the writing edge.
- R8: An index equal to or greater than the word count reads as 0.
- R9: The attribute output always equals the configured word count, `NUM_WORDS`.
- R10: The snapshot changes only on a capture (R6). Block reset clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Block reset, synchronous, active low |
| sys_reset_i | input | 1 | System-reset event, one cycle per event |
| info_i | input | NUM_WORDS*32 | Live crash-info vector, word k at bits 32k+31:32k |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data: bit 0 enable, bits 7:4 index |
| lock_we_i | input | 1 | Lock register write strobe |
| lock_wdata_i | input | 1 | Lock write data; only 0 has an effect |
| ctrl_o | output | 8 | Control register readback |
| lock_o | output | 1 | Lock state; 1 means the control register is writable |
| word_cnt_o | output | 5 | Number of 32-bit words in the dump |
| rdata_o | output | 32 | Snapshot word selected by the index |

## Verification
Every control, lock and capture effect lands at the first rising edge after the stimulus is applied. It is visible at the outputs for the rest of that cycle, because the read value is a combinational select from registered state. The bench applies inputs just after a falling edge. A reference model updates on the following rising edge, and all outputs are compared at the next falling edge, so each result is sampled exactly one edge after its cause. The attribute output has no latency and is compared in every cycle.

// File: rtl/crash_dump_pkg.sv
// Package: shared constants and the control-register layout for the crash
// dump capture block. Assumes a 4-bit word index, so at most 16 words.
package crash_dump_pkg;
    localparam int MAX_WORDS = 16;
    localparam int IDX_W     = 4;
    localparam int CNT_W     = IDX_W + 1;
    localparam int CTRL_W    = 8;
    localparam int EN_BIT    = 0;
    localparam int IDX_LSB   = 4;

    // Architectural control state.
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             en;
    } dump_ctrl_t;

    // Pack the control state into the readback layout.
    function automatic logic [CTRL_W-1:0] pack_ctrl(dump_ctrl_t c);
        logic [CTRL_W-1:0] v;
        v = '0;
        v[EN_BIT] = c.en;
        v[IDX_LSB +: IDX_W] = c.idx;
        return v;
    endfunction
endpackage

// File: rtl/crash_ctrl_regs.sv
// Module: control and lock registers of the crash dump block.
// Holds the capture enable, the read index and the write-zero-to-clear lock.
// A system-reset event clears the enable and requests a capture if it was set.
// Assumes sys_reset_i is synchronous to clk_i and reset is synchronous, active low.
module crash_ctrl_regs
    import crash_dump_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sys_reset_i,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              lock_we_i,
    input  logic              lock_wdata_i,
    output dump_ctrl_t        ctrl_o,
    output logic              lock_o,
    output logic              capture_o
);
    dump_ctrl_t ctrl_q;
    logic       lock_q;
    logic       ctrl_wr_ok;

    // Decide whether a control write is accepted this cycle (lock value before the edge).
    always_comb begin
        ctrl_wr_ok = ctrl_we_i && lock_q && !sys_reset_i;
        capture_o  = sys_reset_i && ctrl_q.en;
    end

    // Update the enable and index: a system reset wins over a software write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else if (sys_reset_i) begin
            ctrl_q.en <= 1'b0;
        end else if (ctrl_wr_ok) begin
            ctrl_q.en  <= ctrl_wdata_i[EN_BIT];
            ctrl_q.idx <= ctrl_wdata_i[IDX_LSB +: IDX_W];
        end
    end

    // Lock bit: software can only clear it; block reset sets it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lock_q <= 1'b1;
        end else if (lock_we_i && !lock_wdata_i) begin
            lock_q <= 1'b0;
        end
    end

    assign ctrl_o = ctrl_q;
    assign lock_o = lock_q;
endmodule

// File: rtl/crash_snapshot_store.sv
// Module: word-wise snapshot storage for the crash dump.
// Latches every word of the live vector on a capture strike and holds it
// otherwise. Assumes capture_i is one cycle per event; reset synchronous, active low.
module crash_snapshot_store #(
    parameter int NUM_WORDS = 12,
    parameter int WORD_W    = 32
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          capture_i,
    input  logic [NUM_WORDS*WORD_W-1:0]   info_i,
    output logic [NUM_WORDS*WORD_W-1:0]   snap_o
);
    genvar g;
    generate
        for (g = 0; g < NUM_WORDS; g++) begin : g_word
            logic [WORD_W-1:0] word_q;
            // Hold one snapshot word; load it on capture.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    word_q <= '0;
                end else if (capture_i) begin
                    word_q <= info_i[g*WORD_W +: WORD_W];
                end
            end
            assign snap_o[g*WORD_W +: WORD_W] = word_q;
        end
    endgenerate
endmodule

// File: rtl/crash_word_select.sv
// Module: index-driven readout of one snapshot word.
// Returns zero for an index at or past the word count. Purely combinational.
module crash_word_select #(
    parameter int NUM_WORDS = 12,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 4
) (
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [NUM_WORDS*WORD_W-1:0]   snap_i,
    output logic [WORD_W-1:0]             rdata_o
);
    // Select the word whose position matches the index; default zero.
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (idx_i == IDX_W'(k)) begin
                rdata_o = snap_i[k*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/crash_dump_capture.sv
// Module: crash dump capture top level.
// Snapshots a wide crash-info vector on a system-reset event while armed,
// keeps it across system resets, and exposes it one 32-bit word at a time.
// Assumes 1 <= NUM_WORDS <= 16 and all inputs synchronous to clk_i.
module crash_dump_capture
    import crash_dump_pkg::*;
#(
    parameter int NUM_WORDS = 12,
    parameter int WORD_W    = 32
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        sys_reset_i,
    input  logic [NUM_WORDS*WORD_W-1:0] info_i,
    input  logic                        ctrl_we_i,
    input  logic [CTRL_W-1:0]           ctrl_wdata_i,
    input  logic                        lock_we_i,
    input  logic                        lock_wdata_i,
    output logic [CTRL_W-1:0]           ctrl_o,
    output logic                        lock_o,
    output logic [CNT_W-1:0]            word_cnt_o,
    output logic [WORD_W-1:0]           rdata_o
);
    localparam int INFO_W = NUM_WORDS * WORD_W;

    dump_ctrl_t        ctrl;
    logic              capture;
    logic [INFO_W-1:0] snap;

    crash_ctrl_regs u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sys_reset_i  (sys_reset_i),
        .ctrl_we_i    (ctrl_we_i),
        .ctrl_wdata_i (ctrl_wdata_i),
        .lock_we_i    (lock_we_i),
        .lock_wdata_i (lock_wdata_i),
        .ctrl_o       (ctrl),
        .lock_o       (lock_o),
        .capture_o    (capture)
    );

    crash_snapshot_store #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (capture),
        .info_i    (info_i),
        .snap_o    (snap)
    );

    crash_word_select #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_sel (
        .idx_i   (ctrl.idx),
        .snap_i  (snap),
        .rdata_o (rdata_o)
    );

    // Expose the readback layout and the constant word count.
    always_comb begin
        ctrl_o     = pack_ctrl(ctrl);
        word_cnt_o = CNT_W'(NUM_WORDS);
    end
endmodule

// File: rtl/crash_dump_capture_chk.sv
// Module: assertion checker for crash_dump_capture, attached by bind.
// Observes ports only. Assumes the default port layout of the control register.
module crash_dump_capture_chk
    import crash_dump_pkg::*;
#(
    parameter int NUM_WORDS = 12,
    parameter int WORD_W    = 32
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        sys_reset_i,
    input logic [NUM_WORDS*WORD_W-1:0] info_i,
    input logic                        ctrl_we_i,
    input logic                        lock_we_i,
    input logic                        lock_wdata_i,
    input logic [CTRL_W-1:0]           ctrl_o,
    input logic                        lock_o,
    input logic [WORD_W-1:0]           rdata_o
);
    localparam logic [CNT_W-1:0] NW = CNT_W'(NUM_WORDS);

    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic [WORD_W-1:0] live_word;

    // Word of the live vector at the current index, for capture checks.
    always_comb begin
        idx       = ctrl_o[IDX_LSB +: IDX_W];
        in_range  = {1'b0, idx} < NW;
        live_word = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (idx == IDX_W'(k)) live_word = info_i[k*WORD_W +: WORD_W];
        end
    end

    a_r3_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_o |=> !lock_o);

    a_r3_lock_set_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_o && !(lock_we_i && !lock_wdata_i)) |=> lock_o);

    a_r4_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lock_o && !sys_reset_i) |=> $stable(ctrl_o));

    a_r5_sys_clears_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_reset_i |=> (ctrl_o[EN_BIT] == 1'b0 && $stable(ctrl_o[IDX_LSB +: IDX_W])));

    a_r6_capture_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sys_reset_i && ctrl_o[EN_BIT] && in_range) |=> rdata_o == $past(live_word));

    a_r8_out_of_range_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_range |-> rdata_o == '0);

    a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(sys_reset_i && ctrl_o[EN_BIT]) && !ctrl_we_i) |=> $stable(rdata_o));

    a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_o[3:1] == 3'b000);
endmodule

bind crash_dump_capture crash_dump_capture_chk #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sys_reset_i  (sys_reset_i),
    .info_i       (info_i),
    .ctrl_we_i    (ctrl_we_i),
    .lock_we_i    (lock_we_i),
    .lock_wdata_i (lock_wdata_i),
    .ctrl_o       (ctrl_o),
    .lock_o       (lock_o),
    .rdata_o      (rdata_o)
);

// File: tb/crash_dump_capture_tb.sv
module crash_dump_capture_tb;
    localparam int NW = 12;
    localparam int WW = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              sys_reset;
    logic [NW*WW-1:0]  info;
    logic              ctrl_we;
    logic [7:0]        ctrl_wd;
    logic              lock_we;
    logic              lock_wd;
    logic [7:0]        ctrl_rd;
    logic              lock_rd;
    logic [4:0]        cnt_rd;
    logic [WW-1:0]     rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state.
    bit          m_en;
    logic [3:0]  m_idx;
    bit          m_lock;
    logic [WW-1:0] m_snap [NW];

    always #4 clk = ~clk;

    crash_dump_capture #(.NUM_WORDS(NW), .WORD_W(WW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .sys_reset_i(sys_reset), .info_i(info),
        .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .lock_we_i(lock_we),
        .lock_wdata_i(lock_wd), .ctrl_o(ctrl_rd), .lock_o(lock_rd),
        .word_cnt_o(cnt_rd), .rdata_o(rdata)
    );

    function automatic logic [WW-1:0] exp_rdata();
        if (m_idx < NW) return m_snap[m_idx];
        return '0;
    endfunction

    function automatic logic [7:0] exp_ctrl();
        return {m_idx, 3'b000, m_en};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " R2/R4/R5 ctrl"}, 64'(ctrl_rd), 64'(exp_ctrl()));
        check({tag, " R3 lock"}, 64'(lock_rd), 64'(m_lock));
        check({tag, " R7/R8/R10 rdata"}, 64'(rdata), 64'(exp_rdata()));
        check({tag, " R9 count"}, 64'(cnt_rd), 64'(NW));
    endtask

    task automatic idle_inputs();
        sys_reset = 0; ctrl_we = 0; ctrl_wd = '0; lock_we = 0; lock_wd = 1;
        for (int k = 0; k < NW; k++) info[k*WW +: WW] = $urandom;
    endtask

    // Apply current inputs for one edge, update model, compare at falling edge.
    task automatic step(string tag);
        bit wr_ok;
        @(posedge clk);
        wr_ok = ctrl_we && m_lock && !sys_reset;
        if (sys_reset && m_en)
            for (int k = 0; k < NW; k++) m_snap[k] = info[k*WW +: WW];
        if (sys_reset) m_en = 0;
        else if (wr_ok) begin m_en = ctrl_wd[0]; m_idx = ctrl_wd[7:4]; end
        if (lock_we && !lock_wd) m_lock = 0;
        @(negedge clk);
        check_all(tag);
        idle_inputs();
    endtask

    task automatic wr_ctrl(logic [7:0] v, string tag);
        ctrl_we = 1; ctrl_wd = v; step(tag);
    endtask

    task automatic do_reset();
        rst_n = 0; idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_en = 0; m_idx = '0; m_lock = 1;
        for (int k = 0; k < NW; k++) m_snap[k] = '0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R1: reset state
        check("R1 ctrl", 64'(ctrl_rd), 64'h0);
        check("R1 lock", 64'(lock_rd), 64'h1);
        check("R1 rdata", 64'(rdata), 64'h0);
        check("R9 count", 64'(cnt_rd), 64'(NW));

        // R2: arm with index 3, R6: capture on system reset, R5: enable drops
        wr_ctrl(8'h31, "R2 arm");
        check("R2 reserved bits", 64'(ctrl_rd[3:1]), 64'h0);
        sys_reset = 1; step("R6 capture");
        check("R5 en cleared", 64'(ctrl_rd[0]), 64'h0);
        // R6/R10: second system reset while disarmed keeps snapshot
        sys_reset = 1; step("R6 no capture disarmed");
        // R7: walk every index including out-of-range ones (R8)
        for (int i = 0; i < 16; i++) wr_ctrl(8'(i << 4), "R7/R8 walk");
        // R5: control write in same cycle as system reset is dropped
        wr_ctrl(8'h21, "R2 rearm");
        sys_reset = 1; ctrl_we = 1; ctrl_wd = 8'h51; step("R5 write dropped");
        check("R5 idx kept", 64'(ctrl_rd[7:4]), 64'h2);
        // R4: lock clear and write in same cycle: write lands
        lock_we = 1; lock_wd = 0; ctrl_we = 1; ctrl_wd = 8'h41; step("R4 same cycle");
        check("R4 same-cycle write", 64'(ctrl_rd), 64'h41);
        // R4: locked writes ignored; R3: setting lock ignored
        wr_ctrl(8'h70, "R4 locked write");
        lock_we = 1; lock_wd = 1; step("R3 set ignored");
        check("R3 still locked", 64'(lock_rd), 64'h0);
        // R6: capture still works while locked (enable was armed)
        sys_reset = 1; step("R6 capture locked");

        // Random phase, with periodic block resets (R10 clears snapshot)
        for (int r = 0; r < 4; r++) begin
            do_reset();
            check_all("R1 rand reset");
            for (int n = 0; n < 600; n++) begin
                int op = $urandom_range(0, 9);
                if (op < 4) begin ctrl_we = 1; ctrl_wd = 8'($urandom); end
                else if (op < 6) sys_reset = 1;
                else if (op == 6 && $urandom_range(0, 9) == 0) begin
                    lock_we = 1; lock_wd = 1'($urandom);
                end
                step("rand");
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule